// File: doc/BRIEF.md
# Deferred Store Write-Back Unit

This block lets store orders whose data arrives late from an execution unit go through the operand pipeline without a long stall. When such an order enters stage 4, the block keeps the line address and the half-word select of that order in a side register and marks the side register busy. The pipeline then keeps moving. When the result comes back and the order has already committed, the block raises a wait for one cycle. In that cycle it writes the 32-bit result into the selected half of the 64-bit line in its register-array value store, and then it frees the side register.

While the side register is busy, two interlocks protect it. The first is a stage-2 hold, raised when a second deferred store is at stage 2; it places a dummy order into stage 3. The second is a stage-4 hold, raised when an order entering stage 4 addresses the saved line or is itself a deferred store; it places a dummy order into stage 5. A control transfer that arrives before the store has left the last stage drops the pending write and releases both holds. A control transfer that arrives after the store has left the last stage leaves the write pending, and the write still completes.

Top module: `store_defer_unit`

## Requirements
- R1: After reset, `pend_busy`, `hold_s2`, `bubble_s3`, `hold_s4`, `bubble_s5`, `wait_beat` and `wr_en` are 0, and every line of the value store reads as zero.
- R2: Capture rule, with `pend_busy` at 0:
  - When `s4_enter` and `s4_dstore` are both 1, `s4_line` and `s4_half` are saved.
  - `pend_busy` reads 1 from the next cycle.
  - `hold_s4` stays 0 during the capture cycle.
- R3: With `pend_busy` at 1, `hold_s2` and `bubble_s3` are 1 in the same cycle exactly when `s2_valid` and `s2_dstore` are both 1.
- R4: With `pend_busy` at 1 and `s4_enter` at 1, `hold_s4` and `bubble_s5` are 1 in the same cycle exactly when `s4_line` equals the saved line or `s4_dstore` is 1. A held deferred store does not replace the saved line.
- R5: Return and write timing:
  - A return (`ret_valid`) is accepted when `pend_busy` is 1 and the order has committed (`store_issued` seen earlier or in the same cycle).
  - In the next cycle, `wait_beat` and `wr_en` are 1, with `wr_line`, `wr_half` and `wr_data` carrying the saved line, the saved half and the returned data.
  - In the cycle after that, `pend_busy` and `wait_beat` are 0.
- R6: A write changes only the selected half and leaves the other half as it was. Half 0 is bits 31:0 of the line and half 1 is bits 63:32. The new value can be read on `rd_data` from the cycle after `wr_en`.
- R7: A `flush` while pending and not committed has these effects:
  - `pend_busy` goes to 0 in the next cycle, which releases both holds.
  - The dropped store is never written.
- R8: Once the order has committed, a `flush` does not drop the pending write. A `flush` in the same cycle as an accepted return still produces the write.
- R9: A `ret_valid` while nothing is pending, or while the pending order has not committed, is ignored. No write follows and the value store is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s2_valid | input | 1 | Stage 2 holds a valid order |
| s2_dstore | input | 1 | Stage 2 order is a deferred store |
| s4_enter | input | 1 | An order is entering stage 4 this cycle |
| s4_dstore | input | 1 | Entering stage-4 order is a deferred store |
| s4_line | input | LINE_AW | Line register value of the entering stage-4 order |
| s4_half | input | 1 | Half-word select of the entering stage-4 order |
| store_issued | input | 1 | The pending store leaves the final stage (commit) |
| flush | input | 1 | Control transfer discards the pipeline |
| ret_valid | input | 1 | Execution unit returns store data |
| ret_data | input | DATA_W | Returned store data |
| rd_line | input | LINE_AW | Read address of the value store |
| hold_s2 | output | 1 | Hold beats at the stage 3 inputs |
| bubble_s3 | output | 1 | Load a dummy order into stage 3 |
| hold_s4 | output | 1 | Hold beats at the stage 5 inputs |
| bubble_s5 | output | 1 | Load a dummy order into stage 5 |
| wait_beat | output | 1 | Pipeline paused for the write-back |
| pend_busy | output | 1 | Side register in use |
| wr_en | output | 1 | Value store write strobe |
| wr_line | output | LINE_AW | Value store write line |
| wr_half | output | 1 | Value store write half |
| wr_data | output | DATA_W | Value store write data |
| rd_data | output | 2*DATA_W | Value store read data |

## Verification
On every cycle, the assertions check the following:
- The saved line and half stay fixed while a write is pending.
- Every capture marks the block busy.
- The wait lasts one cycle and frees the side register.
- A write happens only for a committed order.
- An uncommitted flush never leads to a write.
- No hold is raised unless something is pending.

Some properties can only be shown by the bench's scenarios. These are the following:
- The exact line-match and second-store hazard patterns.
- The preservation of the untouched half-word.
- That a flush in the same cycle as a return still writes.
- That a discarded or uncommitted store never reaches the value store.

// File: rtl/dswb_pkg.sv
// Shared types of the deferred store write-back unit.
// Assumes: nothing beyond the parameters of the modules that import it.
package dswb_pkg;

    // Life cycle of the single side (saved-line) register.
    typedef enum logic [1:0] {
        PS_IDLE  = 2'd0,   // nothing pending
        PS_BUSY  = 2'd1,   // line saved, waiting for commit and data
        PS_WRITE = 2'd2    // data latched, write-back beat in progress
    } pend_state_t;

endpackage

// File: rtl/dswb_hazard.sv
// Stage-2 and stage-4 interlocks for the deferred store write-back unit.
// Does: raises holds and bubble requests while the side register is busy.
// Assumes: busy_i comes from a register, so no combinational loop forms.
module dswb_hazard #(
    parameter int LINE_AW = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               busy_i,
    input  logic [LINE_AW-1:0] saved_line_i,
    input  logic               s2_valid,
    input  logic               s2_dstore,
    input  logic               s4_enter,
    input  logic               s4_dstore,
    input  logic [LINE_AW-1:0] s4_line,
    output logic               hold_s2,
    output logic               bubble_s3,
    output logic               hold_s4,
    output logic               bubble_s5
);

    logic line_hit;

    // Line compare between the entering stage-4 order and the saved line.
    always_comb line_hit = (s4_line == saved_line_i);

    // Interlock decode: a second store at stage 2, a conflict at stage 4.
    always_comb begin
        hold_s2   = busy_i && s2_valid && s2_dstore;
        bubble_s3 = hold_s2;
        hold_s4   = busy_i && s4_enter && (line_hit || s4_dstore);
        bubble_s5 = hold_s4;
    end

    AST_HOLD_ONLY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_s2 || hold_s4) |-> busy_i);  // R3

endmodule

// File: rtl/dswb_value_array.sv
// Value field store: a register array of 64-bit lines.
// Does: half-line writes and an asynchronous full-line read.
// Assumes: only the write-back port of this unit writes it.
module dswb_value_array #(
    parameter int LINE_AW = 5,
    parameter int DATA_W  = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [LINE_AW-1:0]   wr_line,
    input  logic                 wr_half,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [LINE_AW-1:0]   rd_line,
    output logic [2*DATA_W-1:0]  rd_data
);

    localparam int LINES = 2 ** LINE_AW;

    logic [DATA_W-1:0] lo_q [LINES];
    logic [DATA_W-1:0] hi_q [LINES];

    // Clear on reset; overwrite only the selected half of the addressed line.
    always_ff @(posedge clk) begin
        for (int i = 0; i < LINES; i++) begin
            if (!rst_n) begin
                lo_q[i] <= '0;
                hi_q[i] <= '0;
            end else if (wr_en && (wr_line == LINE_AW'(i))) begin
                if (wr_half) hi_q[i] <= wr_data;
                else         lo_q[i] <= wr_data;
            end
        end
    end

    // Full-line read.
    always_comb rd_data = {hi_q[rd_line], lo_q[rd_line]};

endmodule

// File: rtl/dswb_tracker.sv
// Pending-store tracker: saved line, half select, commit mark and data latch.
// Does: captures at stage 4, takes the result, drives one write beat.
//       A flush drops the pending write only before commit.
// Assumes: cap_block_i is the stage-4 hold, which is 0 whenever idle.
module dswb_tracker
    import dswb_pkg::*;
#(
    parameter int LINE_AW = 5,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cap_req_i,
    input  logic               cap_block_i,
    input  logic [LINE_AW-1:0] cap_line_i,
    input  logic               cap_half_i,
    input  logic               store_issued,
    input  logic               flush,
    input  logic               ret_valid,
    input  logic [DATA_W-1:0]  ret_data,
    output logic               busy_o,
    output logic [LINE_AW-1:0] saved_line_o,
    output logic               wait_beat,
    output logic               wr_en,
    output logic [LINE_AW-1:0] wr_line,
    output logic               wr_half,
    output logic [DATA_W-1:0]  wr_data
);

    pend_state_t        st_q;
    logic [LINE_AW-1:0] sv_line_q;
    logic               sv_half_q;
    logic               commit_q;
    logic [DATA_W-1:0]  ho_q;
    logic               cap, commit_now, ret_take, cancel;

    // Event decode for the current cycle.
    always_comb begin
        cap        = (st_q == PS_IDLE) && cap_req_i && !cap_block_i;
        commit_now = commit_q || store_issued;
        ret_take   = (st_q == PS_BUSY) && ret_valid && commit_now;
        cancel     = (st_q == PS_BUSY) && flush && !commit_now;
    end

    // State sequencing: capture, commit, return or cancel, write beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= PS_IDLE;
            commit_q <= 1'b0;
        end else begin
            case (st_q)
                PS_IDLE: if (cap) begin
                    st_q     <= PS_BUSY;
                    commit_q <= 1'b0;
                end
                PS_BUSY: begin
                    if (store_issued) commit_q <= 1'b1;
                    if (ret_take)    st_q <= PS_WRITE;
                    else if (cancel) st_q <= PS_IDLE;
                end
                PS_WRITE: begin
                    st_q     <= PS_IDLE;
                    commit_q <= 1'b0;
                end
                default: st_q <= PS_IDLE;
            endcase
        end
    end

    // Side register: line and half saved at capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sv_line_q <= '0;
            sv_half_q <= 1'b0;
        end else if (cap) begin
            sv_line_q <= cap_line_i;
            sv_half_q <= cap_half_i;
        end
    end

    // Highway data latch: holds returned data for the write beat.
    always_ff @(posedge clk) begin
        if (!rst_n)        ho_q <= '0;
        else if (ret_take) ho_q <= ret_data;
    end

    // Outputs: busy flag, wait and the write port of the write beat.
    always_comb begin
        busy_o       = (st_q != PS_IDLE);
        saved_line_o = sv_line_q;
        wait_beat    = (st_q == PS_WRITE);
        wr_en        = (st_q == PS_WRITE);
        wr_line      = sv_line_q;
        wr_half      = sv_half_q;
        wr_data      = ho_q;
    end

    AST_CAPTURE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> busy_o);  // R2
    AST_SAVED_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PS_BUSY) |=> ($stable(sv_line_q) && $stable(sv_half_q)));  // R2
    AST_WAIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wait_beat |=> (!wait_beat && !busy_o));  // R5
    AST_WRITE_COMMITTED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> commit_q);  // R8
    AST_CANCEL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == PS_BUSY) && flush && !commit_q && !store_issued) |=> (!wr_en && !busy_o));  // R7

endmodule

// File: rtl/store_defer_unit.sv
// Deferred store write-back unit (top).
// Does: joins the tracker, the stage interlocks and the value store.
// Assumes: the pipeline honours hold/bubble and wait in the cycle they appear.
module store_defer_unit #(
    parameter int LINE_AW = 5,
    parameter int DATA_W  = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                s2_valid,
    input  logic                s2_dstore,
    input  logic                s4_enter,
    input  logic                s4_dstore,
    input  logic [LINE_AW-1:0]  s4_line,
    input  logic                s4_half,
    input  logic                store_issued,
    input  logic                flush,
    input  logic                ret_valid,
    input  logic [DATA_W-1:0]   ret_data,
    input  logic [LINE_AW-1:0]  rd_line,
    output logic                hold_s2,
    output logic                bubble_s3,
    output logic                hold_s4,
    output logic                bubble_s5,
    output logic                wait_beat,
    output logic                pend_busy,
    output logic                wr_en,
    output logic [LINE_AW-1:0]  wr_line,
    output logic                wr_half,
    output logic [DATA_W-1:0]   wr_data,
    output logic [2*DATA_W-1:0] rd_data
);

    logic [LINE_AW-1:0] saved_line;

    dswb_hazard #(.LINE_AW(LINE_AW)) u_hazard (
        .clk          (clk),
        .rst_n        (rst_n),
        .busy_i       (pend_busy),
        .saved_line_i (saved_line),
        .s2_valid     (s2_valid),
        .s2_dstore    (s2_dstore),
        .s4_enter     (s4_enter),
        .s4_dstore    (s4_dstore),
        .s4_line      (s4_line),
        .hold_s2      (hold_s2),
        .bubble_s3    (bubble_s3),
        .hold_s4      (hold_s4),
        .bubble_s5    (bubble_s5)
    );

    dswb_tracker #(.LINE_AW(LINE_AW), .DATA_W(DATA_W)) u_tracker (
        .clk          (clk),
        .rst_n        (rst_n),
        .cap_req_i    (s4_enter && s4_dstore),
        .cap_block_i  (hold_s4),
        .cap_line_i   (s4_line),
        .cap_half_i   (s4_half),
        .store_issued (store_issued),
        .flush        (flush),
        .ret_valid    (ret_valid),
        .ret_data     (ret_data),
        .busy_o       (pend_busy),
        .saved_line_o (saved_line),
        .wait_beat    (wait_beat),
        .wr_en        (wr_en),
        .wr_line      (wr_line),
        .wr_half      (wr_half),
        .wr_data      (wr_data)
    );

    dswb_value_array #(.LINE_AW(LINE_AW), .DATA_W(DATA_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_line (wr_line),
        .wr_half (wr_half),
        .wr_data (wr_data),
        .rd_line (rd_line),
        .rd_data (rd_data)
    );

    AST_WRITE_PAUSES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> wait_beat);  // R5

endmodule

// File: tb/store_defer_unit_bench.sv
module store_defer_unit_bench;

    localparam int AW = 5;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic s2_valid = 0, s2_dstore = 0, s4_enter = 0, s4_dstore = 0, s4_half = 0;
    logic [AW-1:0] s4_line = '0, rd_line = '0;
    logic store_issued = 0, flush = 0, ret_valid = 0;
    logic [DW-1:0] ret_data = '0;
    logic hold_s2, bubble_s3, hold_s4, bubble_s5, wait_beat, pend_busy, wr_en, wr_half;
    logic [AW-1:0] wr_line;
    logic [DW-1:0] wr_data;
    logic [2*DW-1:0] rd_data;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    store_defer_unit #(.LINE_AW(AW), .DATA_W(DW)) u_store_defer_unit (
        .clk(clk), .rst_n(rst_n), .s2_valid(s2_valid), .s2_dstore(s2_dstore),
        .s4_enter(s4_enter), .s4_dstore(s4_dstore), .s4_line(s4_line), .s4_half(s4_half),
        .store_issued(store_issued), .flush(flush), .ret_valid(ret_valid), .ret_data(ret_data),
        .rd_line(rd_line), .hold_s2(hold_s2), .bubble_s3(bubble_s3), .hold_s4(hold_s4),
        .bubble_s5(bubble_s5), .wait_beat(wait_beat), .pend_busy(pend_busy), .wr_en(wr_en),
        .wr_line(wr_line), .wr_half(wr_half), .wr_data(wr_data), .rd_data(rd_data)
    );

    // Hazard vectors with line 5 pending:
    // {s2_valid, s2_dstore, s4_enter, s4_dstore, s4_line[4:0], exp_hold2, exp_hold4}
    localparam logic [10:0] VEC [8] = '{
        {1'b1, 1'b1, 1'b0, 1'b0, 5'd0, 1'b1, 1'b0},  // R3 second store at stage 2
        {1'b1, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0},  // R3 plain order
        {1'b0, 1'b1, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0},  // R3 not valid
        {1'b0, 1'b0, 1'b1, 1'b0, 5'd5, 1'b0, 1'b1},  // R4 same line
        {1'b0, 1'b0, 1'b1, 1'b0, 5'd6, 1'b0, 1'b0},  // R4 other line
        {1'b0, 1'b0, 1'b1, 1'b1, 5'd7, 1'b0, 1'b1},  // R4 second store at stage 4
        {1'b0, 1'b0, 1'b0, 1'b0, 5'd5, 1'b0, 1'b0},  // R4 nothing entering
        {1'b1, 1'b1, 1'b1, 1'b0, 5'd5, 1'b1, 1'b1}   // R3 R4 both
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_in();
        s2_valid = 0; s2_dstore = 0; s4_enter = 0; s4_dstore = 0; s4_half = 0;
        s4_line = '0; store_issued = 0; flush = 0; ret_valid = 0; ret_data = '0;
    endtask

    // Capture a deferred store at stage 4 (called at a negedge).
    task automatic capture(input logic [AW-1:0] ln, input logic hf);
        s4_enter = 1; s4_dstore = 1; s4_line = ln; s4_half = hf;
        #1 chk("R2 no hold on capture", hold_s4, 0);
        step();
        clear_in();
        chk("R2 busy after capture", pend_busy, 1);
    endtask

    task automatic read_line(input logic [AW-1:0] ln, input string req, input logic [63:0] exp);
        rd_line = ln;
        #1 chk(req, rd_data, exp);
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        step(); step();
        rst_n = 1;
        step();
        // R1 reset state
        chk("R1 busy", pend_busy, 0);
        chk("R1 holds", {hold_s2, bubble_s3, hold_s4, bubble_s5}, 0);
        chk("R1 wait/wr", {wait_beat, wr_en}, 0);
        read_line(5'd5, "R1 store zero", 64'h0);

        // R2 capture line 5 low half, then walk the hazard table
        capture(5'd5, 1'b0);
        for (int i = 0; i < 8; i++) begin
            {s2_valid, s2_dstore, s4_enter, s4_dstore, s4_line} = VEC[i][10:2];
            #1;
            chk($sformatf("R3 hold_s2 vec%0d", i), {hold_s2, bubble_s3}, {2{VEC[i][1]}});
            chk($sformatf("R4 hold_s4 vec%0d", i), {hold_s4, bubble_s5}, {2{VEC[i][0]}});
            step();
        end
        clear_in();
        chk("R4 held store kept pending", pend_busy, 1);

        // R5 commit, then return: write beat next cycle
        store_issued = 1; step(); clear_in();
        ret_valid = 1; ret_data = 32'h1122_3344;
        step(); clear_in();
        chk("R5 wait", wait_beat, 1);
        chk("R5 write port", {wr_en, 27'd0, wr_line, 31'd0, wr_half}, {1'b1, 27'd0, 5'd5, 32'd0});
        chk("R5 write data", wr_data, 32'h1122_3344);
        step();
        chk("R5 released", {pend_busy, wait_beat}, 0);
        read_line(5'd5, "R6 low half written", 64'h0000_0000_1122_3344);
        // R4 the saved line was not replaced by held store on line 7
        read_line(5'd7, "R4 line 7 untouched", 64'h0);

        // R8 committed store survives a later flush; R6 high half keeps low
        capture(5'd5, 1'b1);
        store_issued = 1; step(); clear_in();
        flush = 1; step(); clear_in();
        chk("R8 flush after commit keeps pending", pend_busy, 1);
        ret_valid = 1; ret_data = 32'hAABB_CCDD; step(); clear_in();
        chk("R8 write after flush", {wr_en, wr_half}, 2'b11);
        step();
        read_line(5'd5, "R6 both halves", 64'hAABB_CCDD_1122_3344);

        // R8 flush and return in the same cycle, committed in that cycle
        capture(5'd9, 1'b0);
        store_issued = 1; flush = 1; ret_valid = 1; ret_data = 32'h0BAD_F00D;
        step(); clear_in();
        chk("R8 same-cycle flush+return writes", {wr_en, wr_data}, {1'b1, 32'h0BAD_F00D});
        step();
        read_line(5'd9, "R8 line 9", 64'h0000_0000_0BAD_F00D);

        // R7 flush before commit drops the store and releases holds
        capture(5'd12, 1'b1);
        flush = 1; step(); clear_in();
        chk("R7 busy cleared", pend_busy, 0);
        s2_valid = 1; s2_dstore = 1; s4_enter = 1; s4_line = 5'd12;
        #1 chk("R7 holds released", {hold_s2, hold_s4}, 0);
        clear_in();
        ret_valid = 1; ret_data = 32'hFFFF_FFFF; step(); clear_in();
        chk("R7 no write after drop", wr_en, 0);
        step();
        read_line(5'd12, "R7 line 12 unchanged", 64'h0);

        // R9 return before commit is ignored
        capture(5'd3, 1'b0);
        ret_valid = 1; ret_data = 32'h5555_AAAA; step(); clear_in();
        chk("R9 uncommitted return ignored", {wr_en, wait_beat, pend_busy}, 3'b001);
        step();
        read_line(5'd3, "R9 line 3 unchanged", 64'h0);
        flush = 1; step(); clear_in();
        chk("R7 cleanup", pend_busy, 0);
        ret_valid = 1; ret_data = 32'h1234_5678; step(); clear_in();
        chk("R9 idle return ignored", wr_en, 0);
        step();
        read_line(5'd3, "R9 line 3 still zero", 64'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule